// File: doc/BRIEF.md
# Multi-Mode PWM Generator

A single-channel pulse-width modulation source that runs on a 100 MHz tick (10 ns per tick). A 2-bit mode value picks one of four behaviours. Off holds the output low. Standard runs a fixed 256-tick frame with an 8-bit duty. Fast emits one-tick pulses, and the duty sets how densely they repeat. Variable-frequency takes separate 13-bit high and low durations.

Software writes configuration through a simple write port. The port has four register addresses: mode, duty, high period and low period. Each write lands in a pending copy. The whole pending set moves into the active set only when the current period ends, so a frame never comes out cut short or stretched. Writing the off mode is the one exception: it stops the output on the next clock.

Top module: `pwm_multimode`

## Requirements
- R1: While reset is held and after it is released, the output is low and the active mode is off.
- R2: A write with `wr_addr` 0 sets the mode from `wr_data[1:0]` (0 off, 1 standard, 2 fast, 3 variable-frequency). Address 1 sets the duty from `wr_data[7:0]`. Address 2 sets the high period and address 3 sets the low period, each from `wr_data[12:0]`.
- R3: In standard mode each period is 256 ticks and the output is high for the first `duty` ticks. A duty of 0 gives a constant low output.
- R4: In standard mode a duty of 255 gives 255 high ticks followed by 1 low tick.
- R5: In fast mode with duty d from 1 to 127, the output is a one-tick high pulse every floor(256/d) ticks on a low background.
- R6: In fast mode with duty d from 128 to 254, the output is a one-tick low pulse every floor(256/(256-d)) ticks on a high background. d = 128 toggles on every tick.
- R7: In fast mode a duty of 0 holds the output constantly low and a duty of 255 holds it constantly high.
- R8: In variable-frequency mode the output is high for hi+1 ticks and then low for lo+1 ticks. Both values use the full 13-bit range.
- R9: A write of duty, high, low or a non-off mode does not change the period in progress. The new values apply from the next period boundary.
- R10: Writing the off mode makes the output low on the clock after the write, and the output stays low while the mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 duty, 2 high period, 3 low period |
| wr_data | input | 13 | Write value, low bits used for mode and duty |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures high and low run lengths on the pin. It targets the edges of each mode's range: the two constant-level duties in fast mode, the 128 switch-over point where the background level flips, the 255/256 maximum in standard mode, and the 8191 high time in variable-frequency mode. If the divider or the background selection were wrong, fast mode would show the wrong spacing or an inverted pulse. If the count were off by one, standard mode would lose or gain a tick and variable-frequency mode would give hi or lo ticks instead of hi+1 or lo+1. A duty write placed just after a rising edge catches a design that applies updates at once, because the current high phase would then have the new length. Writing off while the output is high catches a design that waits for the period to end.

// File: rtl/pwm_mm_pkg.sv
// Package: shared encodings for the multi-mode PWM generator.
// Assumes a 2-bit mode field and a 2-bit register address on the write port.
package pwm_mm_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_STD  = 2'd1,
        PM_FAST = 2'd2,
        PM_VAR  = 2'd3
    } pwm_mode_e;

    typedef enum logic [1:0] {
        RA_MODE = 2'd0,
        RA_DUTY = 2'd1,
        RA_HIGH = 2'd2,
        RA_LOW  = 2'd3
    } pwm_reg_e;

endpackage

// File: rtl/pwm_cfg_shadow.sv
// Module: pending and active configuration registers.
// Writes land in the pending set. The active set copies the pending set
// when `load` (period boundary) is high. A write of the off mode drops the
// active mode to off at once. The fast-mode pulse spacing is computed here
// at load time, so no divider sits on the counting path.
// Assumes HL_W >= DUTY_W and HL_W >= 2.
module pwm_cfg_shadow
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int HL_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HL_W-1:0]   wr_data,
    input  logic              load,
    output pwm_mode_e         act_mode,
    output logic [DUTY_W-1:0] act_duty,
    output logic [HL_W-1:0]   act_hi,
    output logic [HL_W-1:0]   act_lo,
    output logic [DUTY_W:0]   act_span,
    output logic              force_off
);

    localparam logic [DUTY_W:0] FULL = {1'b1, {DUTY_W{1'b0}}};

    pwm_mode_e         pend_mode;
    logic [DUTY_W-1:0] pend_duty;
    logic [HL_W-1:0]   pend_hi;
    logic [HL_W-1:0]   pend_lo;

    // Fast-mode spacing: floor(FULL/d) below half scale, floor(FULL/(FULL-d)) above.
    function automatic logic [DUTY_W:0] span_of(input logic [DUTY_W-1:0] d);
        logic [DUTY_W:0] dv;
        logic [DUTY_W:0] rem;
        logic [DUTY_W:0] q;
        if (d == '0 || d == '1) begin
            return FULL;
        end
        dv  = d[DUTY_W-1] ? (FULL - {1'b0, d}) : {1'b0, d};
        rem = '0;
        q   = '0;
        for (int i = DUTY_W; i >= 0; i--) begin
            rem = {rem[DUTY_W-1:0], FULL[i]};
            if (rem >= dv) begin
                rem  = rem - dv;
                q[i] = 1'b1;
            end
        end
        return q;
    endfunction

    // An off-mode write acts immediately, bypassing the shadow.
    always_comb begin
        force_off = wr_en && (wr_addr == RA_MODE) && (wr_data[1:0] == PM_OFF);
    end

    // Pending registers: take each write as it arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mode <= PM_OFF;
            pend_duty <= '0;
            pend_hi   <= '0;
            pend_lo   <= '0;
        end else if (wr_en) begin
            case (pwm_reg_e'(wr_addr))
                RA_MODE: pend_mode <= pwm_mode_e'(wr_data[1:0]);
                RA_DUTY: pend_duty <= wr_data[DUTY_W-1:0];
                RA_HIGH: pend_hi   <= wr_data;
                RA_LOW:  pend_lo   <= wr_data;
                default: ;
            endcase
        end
    end

    // Active registers: update only at a period boundary, or on a forced off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= PM_OFF;
            act_duty <= '0;
            act_hi   <= '0;
            act_lo   <= '0;
            act_span <= FULL;
        end else if (force_off) begin
            act_mode <= PM_OFF;
        end else if (load) begin
            act_mode <= pend_mode;
            act_duty <= pend_duty;
            act_hi   <= pend_hi;
            act_lo   <= pend_lo;
            act_span <= span_of(pend_duty);
        end
    end

endmodule

// File: rtl/pwm_period_counter.sv
// Module: tick counter for one PWM period.
// Counts from 0 to the last tick of the active mode's period. `wrap` marks
// that last tick and is the load point for new settings. Off mode has a
// one-tick period, so pending settings load on the next clock.
// Assumes the active settings change only when wrap is high or restart is high.
module pwm_period_counter
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int HL_W   = 13,
    localparam int CW    = HL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  pwm_mode_e         act_mode,
    input  logic [DUTY_W:0]   act_span,
    input  logic [HL_W-1:0]   act_hi,
    input  logic [HL_W-1:0]   act_lo,
    output logic [CW-1:0]     cnt,
    output logic [CW-1:0]     last,
    output logic              wrap
);

    localparam logic [CW-1:0] STD_LAST = CW'((1 << DUTY_W) - 1);

    // Last tick index of the current period, per mode.
    always_comb begin
        case (act_mode)
            PM_STD:  last = STD_LAST;
            PM_FAST: last = CW'(act_span) - CW'(1);
            PM_VAR:  last = CW'(act_hi) + CW'(act_lo) + CW'(1);
            default: last = '0;
        endcase
        wrap = (cnt == last);
    end

    // Advance the tick count, restarting at the boundary or on a forced off.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/pwm_wave_shaper.sv
// Module: output level decoder with a registered output.
// Maps the active mode, the duty, the high period and the tick count to the
// pin level, one register deep. A forced off clears the output on the next clock.
// Assumes cnt never exceeds the period's last tick.
module pwm_wave_shaper
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int HL_W   = 13,
    localparam int CW    = HL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_off,
    input  pwm_mode_e         act_mode,
    input  logic [DUTY_W-1:0] act_duty,
    input  logic [HL_W-1:0]   act_hi,
    input  logic [CW-1:0]     cnt,
    output logic              pwm_out
);

    logic level;

    // Per-mode level for the current tick.
    always_comb begin
        case (act_mode)
            PM_STD:  level = (cnt < CW'(act_duty));
            PM_FAST: begin
                if (act_duty == '0) begin
                    level = 1'b0;
                end else if (act_duty == '1) begin
                    level = 1'b1;
                end else if (!act_duty[DUTY_W-1]) begin
                    level = (cnt == '0);
                end else begin
                    level = (cnt != '0);
                end
            end
            PM_VAR:  level = (cnt <= CW'(act_hi));
            default: level = 1'b0;
        endcase
    end

    // Register the level so the pin is free of decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n || force_off) begin
            pwm_out <= 1'b0;
        end else begin
            pwm_out <= level;
        end
    end

endmodule

// File: rtl/pwm_multimode.sv
// Module: multi-mode PWM generator, top level.
// Joins the configuration shadow, the period counter and the output shaper.
// Assumes one tick per clock. Settings apply at period boundaries except
// an off-mode write, which applies on the next clock.
module pwm_multimode
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int HL_W   = 13,
    localparam int CW    = HL_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [HL_W-1:0] wr_data,
    output logic            pwm_out
);

    pwm_mode_e         act_mode;
    logic [DUTY_W-1:0] act_duty;
    logic [HL_W-1:0]   act_hi;
    logic [HL_W-1:0]   act_lo;
    logic [DUTY_W:0]   act_span;
    logic              force_off;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     last;
    logic              wrap;

    pwm_cfg_shadow #(.DUTY_W(DUTY_W), .HL_W(HL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load      (wrap),
        .act_mode  (act_mode),
        .act_duty  (act_duty),
        .act_hi    (act_hi),
        .act_lo    (act_lo),
        .act_span  (act_span),
        .force_off (force_off)
    );

    pwm_period_counter #(.DUTY_W(DUTY_W), .HL_W(HL_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (force_off),
        .act_mode (act_mode),
        .act_span (act_span),
        .act_hi   (act_hi),
        .act_lo   (act_lo),
        .cnt      (cnt),
        .last     (last),
        .wrap     (wrap)
    );

    pwm_wave_shaper #(.DUTY_W(DUTY_W), .HL_W(HL_W)) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (force_off),
        .act_mode  (act_mode),
        .act_duty  (act_duty),
        .act_hi    (act_hi),
        .cnt       (cnt),
        .pwm_out   (pwm_out)
    );

endmodule

// File: rtl/pwm_multimode_checker.sv
// Module: property checker for the multi-mode PWM generator, bound to the top.
// Watches the write port, the output and the hand-off between the shadow
// registers and the period counter.
module pwm_multimode_checker
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int HL_W   = 13,
    localparam int CW    = HL_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_out,
    input logic              force_off,
    input pwm_mode_e         act_mode,
    input logic [DUTY_W-1:0] act_duty,
    input logic [HL_W-1:0]   act_hi,
    input logic [HL_W-1:0]   act_lo,
    input logic [CW-1:0]     cnt,
    input logic [CW-1:0]     last,
    input logic              wrap
);

    // R10: an off-mode write clears the pin on the next clock
    a_r10_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> !pwm_out);

    // R10: the pin stays low while the active mode is off
    a_r10_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == PM_OFF) |=> !pwm_out);

    // R9: active settings move only at a period boundary
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !force_off) |=> ($stable(act_duty) && $stable(act_mode)
                                   && $stable(act_hi) && $stable(act_lo)));

    // R9: the counter never runs past the period's last tick
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    // R7: fast mode at zero duty stays low
    a_r7_fast_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == PM_FAST && act_duty == '0 && !force_off) |=> !pwm_out);

    // R7: fast mode at full-scale duty stays high
    a_r7_fast_full: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == PM_FAST && act_duty == '1 && !force_off) |=> pwm_out);

    // R3: standard mode at zero duty stays low
    a_r3_std_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == PM_STD && act_duty == '0 && !force_off) |=> !pwm_out);

endmodule

bind pwm_multimode pwm_multimode_checker #(.DUTY_W(DUTY_W), .HL_W(HL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_out   (pwm_out),
    .force_off (force_off),
    .act_mode  (act_mode),
    .act_duty  (act_duty),
    .act_hi    (act_hi),
    .act_lo    (act_lo),
    .cnt       (cnt),
    .last      (last),
    .wrap      (wrap)
);

// File: tb/pwm_multimode_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the multi-mode PWM generator. Each task
// programs one setting and checks the measured run lengths on the pin.
module pwm_multimode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic        pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    pwm_multimode u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always #2 clk = ~clk;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 13'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 0;
        prev = pwm_out;
        for (int n = 0; n < 40000; n++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin
                ok = 1;
                break;
            end
            prev = pwm_out;
        end
    endtask

    // Starts on a high sample that follows a rise, ends on the next rise.
    task automatic run_lengths(output int h, output int l);
        h = 1;
        l = 0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (pwm_out) h++;
            else break;
        end
        l = 1;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (!pwm_out) l++;
            else break;
        end
    endtask

    task automatic measure(input string req, input int eh, input int el);
        bit ok;
        int h, l;
        wait_rise(ok);
        check_eq({req, " edge seen"}, int'(ok), 1);
        run_lengths(h, l);
        run_lengths(h, l);
        check_eq({req, " high ticks"}, h, eh);
        check_eq({req, " low ticks"}, l, el);
    endtask

    task automatic count_high(input string req, input int exp);
        int c = 0;
        repeat (600) @(negedge clk);
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if (pwm_out) c++;
        end
        check_eq(req, c, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R1 low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check_eq("R1 low after reset", int'(pwm_out), 0);
    endtask

    task automatic t_standard;
        wr(1, 100); wr(0, 1);
        measure("R2 R3 std duty 100", 100, 156);
        wr(1, 255);
        measure("R4 std duty 255", 255, 1);
        wr(1, 0);
        count_high("R3 std duty 0", 0);
    endtask

    // R9: a duty write right after a rise leaves the running period intact.
    task automatic t_glitch;
        int h, l;
        wr(1, 64);
        measure("R9 std duty 64", 64, 192);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 13'd200;
        run_lengths(h, l);
        check_eq("R9 old high kept", h, 64);
        check_eq("R9 old low kept", l, 192);
        run_lengths(h, l);
        check_eq("R9 new high", h, 200);
        check_eq("R9 new low", l, 56);
    endtask

    task automatic t_fast;
        wr(1, 64); wr(0, 2);
        measure("R5 fast 64", 1, 3);
        wr(1, 1);
        measure("R5 fast 1", 1, 255);
        wr(1, 200);
        measure("R6 fast 200", 3, 1);
        wr(1, 128);
        measure("R6 fast 128", 1, 1);
        wr(1, 0);
        count_high("R7 fast 0 constant low", 0);
        wr(1, 255);
        count_high("R7 fast 255 constant high", 600);
    endtask

    task automatic t_var;
        wr(2, 0); wr(3, 0); wr(0, 3);
        measure("R8 var 0/0", 1, 1);
        wr(2, 5); wr(3, 9);
        measure("R8 var 5/9", 6, 10);
        wr(2, 8191); wr(3, 2);
        measure("R8 var 8191/2", 8192, 3);
    endtask

    task automatic t_off;
        bit ok;
        int h, l;
        wr(1, 200); wr(0, 1);
        wait_rise(ok);
        check_eq("R10 edge seen", int'(ok), 1);
        run_lengths(h, l);
        run_lengths(h, l);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 13'd0;
        @(negedge clk);
        wr_en = 1'b0;
        check_eq("R10 low next clock", int'(pwm_out), 0);
        count_high("R10 stays low", 0);
    endtask

    initial begin
        t_reset();
        t_standard();
        t_glitch();
        t_fast();
        t_var();
        t_off();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule